// File: doc/BRIEF.md
# Page Program Buffer Engine

This block sits behind a serial command front end and handles the data phase of a page-program command. The front end announces the start of a command with a start address, then hands over each received data byte. The engine collects the bytes into a 256-byte page buffer. The column advances inside the addressed page and wraps from 255 back to 0. A bit mask records which buffer columns were filled.

When chip select rises, the front end raises a commit strobe. With it comes the count of bits left over after the last whole byte. The engine starts a program cycle only if five things hold:
- the commit fell on a byte boundary;
- the write-enable latch is set;
- the page is outside the protected region;
- at least one byte arrived;
- the engine is not busy.

During the program cycle a parameterised counter keeps `busy` high. When the counter expires, only the masked columns of the page are ANDed into a small internal array, so bits can only go from 1 to 0. At the same moment `done` pulses for one cycle. The front end uses that pulse to clear its write-enable latch.

A read port exposes the array so that the surrounding logic, and the bench, can observe programmed contents.

Top module: `pgm_buffer_engine`

## Requirements
- R1: Each accepted byte is stored at the current column of the page selected by `start_addr[ADDR_W-1:8]`; the column starts at `start_addr[7:0]`, increments by one per byte, and wraps from 255 to 0 without leaving the page.
- R2: When more than 256 bytes arrive in one command, the later bytes replace earlier buffered bytes at the same column, and only the last value per column is programmed.
- R3: Array bytes whose column received no data during the command keep their previous value, as do all bytes of other pages.
- R4: A program cycle updates each written location to the bitwise AND of its old value and the buffered byte, so no bit ever goes from 0 to 1.
- R5: A commit with a nonzero `partial_bits` value cancels the command: `busy` stays low and the array is unchanged.
- R6: A commit while `wel` is low is rejected with no busy cycle and no array change.
- R7: A commit to a protected page is rejected. The page is protected according to `prot_lvl` as follows:
  - 0: no page is protected;
  - 1: the upper quarter of the pages, where the two top page-index bits are 11, is protected;
  - 2: the upper half, where the top page-index bit is 1, is protected;
  - 3: every page is protected.
- R8: After an accepted commit, `busy` is high for exactly `PROG_CYC` cycles, starting the cycle after the commit edge. When it falls, `done` is high for exactly that one cycle, and the new array contents are readable from that cycle on.
- R9: A commit with no data bytes since the command start is treated as aborted and does not raise `busy`.
- R10: While `busy` is high, `cmd_start`, `byte_valid` and `commit` are ignored.
- R11: An `abort` pulse ends the open command, so a later commit without a new start does not program anything.
- R12: After reset, `busy` and `done` are low and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Opens a new command, clears the buffer mask |
| start_addr | input | ADDR_W | Byte address of the first data byte |
| byte_valid | input | 1 | A received data byte is present |
| byte_data | input | 8 | Received data byte |
| commit | input | 1 | Chip select rose; request the program cycle |
| partial_bits | input | 3 | Bits clocked after the last whole byte at commit |
| abort | input | 1 | Discard the open command |
| wel | input | 1 | Write-enable latch state |
| prot_lvl | input | 2 | Protected region selector |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| busy | output | 1 | Program cycle in progress |
| done | output | 1 | One-cycle pulse as the program cycle ends; clears the latch |

## Verification
The hardest state to reach from the ports is a command that has already been accepted and is counting down, receiving a fresh start, a data byte and a commit in its busy window. In that situation the buffer, the mask and the busy counter could all be disturbed at once. The stimulus fires exactly that sequence on the second to fourth cycles of a program cycle. It then checks two things: that `done` still falls after the original count, and that a second program cycle does not follow. It also reads back the page the stray command targeted and the programmed page itself. Wrap and overflow cases use starts near the page end and a 258-byte stream, so that the last value per column is the one committed.

// File: rtl/pgm_buffer_engine.sv
module pgm_buffer_engine #(
  parameter int ADDR_W   = 11,
  parameter int PROG_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              commit,
  input  logic [2:0]        partial_bits,
  input  logic              abort,
  input  logic              wel,
  input  logic [1:0]        prot_lvl,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done
);
  localparam int PG_W  = ADDR_W - 8;
  localparam int MEM_N = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PROG_CYC + 1);

  logic [7:0]      mem  [MEM_N];
  logic [7:0]      pbuf [256];
  logic [255:0]    vmask;
  logic [7:0]      col;
  logic [PG_W-1:0] page;
  logic            active, any_byte, prot_hit, go;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    case (prot_lvl)
      2'd0:    prot_hit = 1'b0;
      2'd1:    prot_hit = (page[PG_W-1 -: 2] == 2'b11);
      2'd2:    prot_hit = page[PG_W-1];
      default: prot_hit = 1'b1;
    endcase
  end

  assign go      = commit && active && !busy && (partial_bits == 3'd0) && wel && !prot_hit && any_byte;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      any_byte <= 1'b0;
      vmask    <= '0;
      col      <= '0;
      page     <= '0;
    end else if (!busy) begin
      if (cmd_start) begin
        active   <= 1'b1;
        any_byte <= 1'b0;
        vmask    <= '0;
        col      <= start_addr[7:0];
        page     <= start_addr[ADDR_W-1:8];
      end else if (abort || commit) begin
        active <= 1'b0;
      end else if (byte_valid && active) begin
        pbuf[col]  <= byte_data;
        vmask[col] <= 1'b1;
        col        <= col + 8'd1;
        any_byte   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      for (int a = 0; a < MEM_N; a++) mem[a] <= 8'hFF;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(PROG_CYC - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
          for (int c = 0; c < 256; c++)
            if (vmask[c]) mem[{page, 8'(c)}] <= mem[{page, 8'(c)}] & pbuf[c];
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> ($past(wel) && $past(commit))); // R6
  AST_PARTIAL_CANCELS: assert property (@(posedge clk) disable iff (!rst_n) (commit && !busy && partial_bits != 3'd0) |=> !busy); // R5
  AST_EMPTY_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (commit && !busy && !any_byte) |=> !busy); // R9
  AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (commit && !busy && prot_hit) |=> !busy); // R7
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(vmask)); // R10
endmodule

// File: tb/sim_pgm_buffer_engine.sv
module sim_pgm_buffer_engine;
  localparam int AW = 11;
  localparam int PC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, byte_valid = 0, commit = 0, abort = 0, wel = 0;
  logic [AW-1:0] start_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0, rd_data;
  logic [2:0] partial_bits = '0;
  logic [1:0] prot_lvl = '0;
  logic busy, done;

  pgm_buffer_engine #(.ADDR_W(AW), .PROG_CYC(PC)) u0 (
    .clk, .rst_n, .cmd_start, .start_addr, .byte_valid, .byte_data, .commit,
    .partial_bits, .abort, .wel, .prot_lvl, .rd_addr, .rd_data, .busy, .done);

  always #10 clk = ~clk;

  typedef struct { int addr; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int push_n = 0, cmp_n = 0, checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] tb_mem [1 << AW];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      item_t it;
      wait (q.size() > 0);
      it = q.pop_front();
      @(negedge clk);
      rd_addr = AW'(it.addr);
      #2;
      check(rd_data === it.exp, it.tag, rd_data, it.exp);
      cmp_n++;
    end
  end

  task automatic expect_page(int p, string tag);
    for (int c = 0; c < 256; c++) begin
      item_t it;
      it.addr = p * 256 + c; it.exp = tb_mem[p * 256 + c]; it.tag = tag;
      q.push_back(it);
      push_n++;
    end
    wait (cmp_n == push_n);
  endtask

  function automatic bit prot_of(int p);
    case (prot_lvl)
      2'd0: return 0;
      2'd1: return p >= 6;
      2'd2: return p >= 4;
      default: return 1;
    endcase
  endfunction

  task automatic run_cmd(int addr, int n, int seed, int partial, bit junk, string tag);
    logic [7:0] b [256];
    bit m [256];
    int colv = addr % 256, p = addr / 256;
    bit ok, bad;
    for (int c = 0; c < 256; c++) m[c] = 0;
    @(negedge clk); cmd_start = 1; start_addr = AW'(addr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cmd_start = 0; byte_valid = 1;
      byte_data = 8'(seed ^ (i * 37));
      b[colv] = byte_data; m[colv] = 1; colv = (colv + 1) % 256;
    end
    @(negedge clk); cmd_start = 0; byte_valid = 0; commit = 1; partial_bits = 3'(partial);
    ok = (partial == 0) && wel && !prot_of(p) && (n > 0);
    @(negedge clk); commit = 0; partial_bits = 0;
    if (!ok) begin
      check(busy == 0 && done == 0, tag, busy, 0);
    end else begin
      check(busy == 1, {tag, " R8 busy rise"}, busy, 1);
      bad = 0;
      for (int k = 1; k < PC; k++) begin
        @(negedge clk);
        if (junk) begin
          cmd_start = (k == 1); start_addr = AW'(((p + 1) % 8) * 256);
          byte_valid = (k == 2); byte_data = 8'h00;
          commit = (k == 3);
        end
        if (busy !== 1 || done !== 0) bad = 1;
      end
      @(negedge clk); cmd_start = 0; byte_valid = 0; commit = 0;
      check(!bad, {tag, " R8 busy width"}, bad, 0);
      check(busy == 0 && done == 1, {tag, " R8 done pulse"}, {busy, done}, 1);
      for (int c = 0; c < 256; c++)
        if (m[c]) tb_mem[p * 256 + c] = tb_mem[p * 256 + c] & b[c];
      @(negedge clk);
      check(busy == 0 && done == 0, {tag, " R8 R10 after done"}, {busy, done}, 0);
    end
    expect_page(p, tag);
  endtask

  initial begin
    for (int a = 0; a < (1 << AW); a++) tb_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && done == 0, "R12 reset outputs", {busy, done}, 0);
    expect_page(0, "R12 erased array");
    wel = 1;
    run_cmd(256 + 16, 4, 8'hA5, 0, 0, "R1 R3 basic");
    run_cmd(256 + 16, 3, 8'h0F, 0, 0, "R4 clear only");
    run_cmd(2 * 256 + 254, 4, 8'h3C, 0, 0, "R1 wrap");
    run_cmd(3 * 256, 258, 8'h5A, 0, 0, "R2 overflow");
    run_cmd(4 * 256 + 8, 2, 8'h11, 3, 0, "R5 partial");
    wel = 0;
    run_cmd(4 * 256, 2, 8'h22, 0, 0, "R6 no wel");
    wel = 1; prot_lvl = 2'd1;
    run_cmd(7 * 256, 2, 8'h33, 0, 0, "R7 protected");
    run_cmd(5 * 256 + 100, 2, 8'h44, 0, 0, "R7 unprotected");
    prot_lvl = 2'd3;
    run_cmd(1 * 256, 1, 8'h00, 0, 0, "R7 all protected");
    prot_lvl = 2'd0;
    run_cmd(4 * 256, 0, 8'h00, 0, 0, "R9 empty");
    @(negedge clk); cmd_start = 1; start_addr = AW'(6 * 256);
    @(negedge clk); cmd_start = 0; byte_valid = 1; byte_data = 8'h00;
    @(negedge clk); byte_valid = 0; abort = 1;
    @(negedge clk); abort = 0; commit = 1;
    @(negedge clk); commit = 0;
    check(busy == 0, "R11 abort", busy, 0);
    expect_page(6, "R11 abort page");
    run_cmd(6 * 256 + 40, 5, 8'h96, 0, 1, "R10 busy ignore");
    expect_page(7, "R10 stray target page");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(64'd20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule